// File: doc/BRIEF.md
# Byte-Serial 8-Bit Processor Core

This block is a small multi-cycle processor. It reads its instruction stream one byte at a time from a single byte-wide memory port and runs sixteen operation classes on a file of six 8-bit registers. Every instruction starts with a header byte. From that byte alone the core learns the operation, whether the operand is a register or a literal, and how many more bytes follow. It then fetches zero, one or two operand bytes and executes in one cycle. The one exception is the pointer load, which needs a second memory read.

Two registers are paired into a 16-bit pointer that serves indirect memory access and jumps. A separate 16-bit stack pointer serves push and pop. Port input and output use their own byte-wide bus, apart from memory. The core has no interrupts, pipeline or cache. When it meets any encoding outside the defined set, it stops and raises a fault output. The condition flags are visible on an output so that the integration can watch compare results.

Top module: `cpu8_core`

## Requirements
- R1: After reset the program counter is 0x0000, the stack pointer is 0xFFFF, all registers and flags are zero, and `halted` and `fault` are low. The first cycle after reset reads memory at address 0x0000.
- R2: Header byte fields are: bits [7:4] operation, bit 3 register-form select, bits [2:0] register code (0=A, 1=B, 2=C, 3=D, 4=H, 5=Z). Operations 0 and 7–15 take 2 bytes. Load and store take 1 byte in register form and 3 bytes otherwise. Push and jump take 1 byte in register form and 2 bytes otherwise. Pop takes 1 byte. The pointer load (operation 5) takes 3 bytes. Each fetched byte advances the program counter by one.
- R3: Operation 0 copies either a literal second byte or the register coded in the second byte into the named register, and leaves the flags unchanged.
- R4: Operation 9 adds the operand to the named register. Operation 10 also adds the carry flag. The carry flag receives the carry out.
- R5: Operations 11, 12 and 13 write AND, OR and NOR of the named register and the operand back to the named register.
- R6: Operation 15 subtracts the operand and the carry flag, and carry receives the borrow. Operation 14 sets the flags like a subtract without borrow-in and writes no register. The flags output is {carry, zero, less-than (unsigned), equal} in bits [3:0]. Every ALU operation updates all four flags.
- R7: Load (1) and store (2) use a 16-bit address taken from two trailing bytes, low byte first. In register form they use the pointer, with H as the high byte and Z as the low byte.
- R8: Pointer load (5) reads the byte at the trailing address into Z and the byte at that address plus one into H.
- R9: Push (3) decrements the stack pointer and then writes either the named register (register form) or the literal. Pop (4, register form) reads at the stack pointer into the named register and then increments.
- R10: Jump (6) loads the program counter from the pointer when its operand, either the named register or the literal, is nonzero. Otherwise execution continues with the next instruction.
- R11: Port input (7) reads the port given by the operand into the named register. Port output (8) writes the named register to the port given by the operand. The port number is a literal or the register coded in the second byte.
- R12: An undefined encoding stops the core. That means a register code above 5 in either byte, pop without bit 3, literal-form push or jump with a nonzero register field, or a pointer load with bit 3 set or a nonzero register field. The core then sets `halted` and `fault` and issues no further memory or port strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe; data expected on `mem_rdata` in the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| io_port | output | 8 | Port number |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data |
| flags | output | 4 | {carry, zero, less, equal} |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Stop was caused by an undefined encoding |

## Verification
The bench runs a program that mixes 1-, 2- and 3-byte instructions back to back. A decoder that miscounts any length drifts out of step, and every later port or memory write then shows the wrong address or data. Carry chaining is tested across an add that overflows followed by an add-with-carry, and a borrow is carried across two subtracts. A core that dropped the carry input or inverted the borrow would produce an off-by-one result. Two compares are followed by port writes of the compared register, which shows that compare writes no register and that its flags follow a subtract. Stack order, pointer-based store then load, and a taken jump over an output that must never appear are also checked. Separate runs feed an out-of-range source register code and a malformed pop. A core that executed either would make writes the scoreboard does not expect or would never raise its fault.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

   typedef enum logic [3:0] {
      OP_MOV  = 4'h0,
      OP_LD   = 4'h1,
      OP_ST   = 4'h2,
      OP_PUSH = 4'h3,
      OP_POP  = 4'h4,
      OP_LDP  = 4'h5,
      OP_JNZ  = 4'h6,
      OP_IN   = 4'h7,
      OP_OUT  = 4'h8,
      OP_ADD  = 4'h9,
      OP_ADC  = 4'hA,
      OP_AND  = 4'hB,
      OP_OR   = 4'hC,
      OP_NOR  = 4'hD,
      OP_CMP  = 4'hE,
      OP_SBB  = 4'hF
   } opc_e;

   typedef enum logic [2:0] {
      S_FETCH,
      S_OPND1,
      S_OPND2,
      S_EXEC,
      S_PTRHI,
      S_HALT
   } state_e;

   typedef struct packed {
      logic carry;
      logic zero;
      logic less;
      logic equal;
   } flags_t;

   localparam int unsigned IDX_H = 4;
   localparam int unsigned IDX_Z = 5;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
   import cpu8_pkg::*;
#(
   parameter int unsigned SEL_W = 3,
   parameter int unsigned NREGS = 6
) (
   input  logic [7:0]       hdr,
   output opc_e             opc,
   output logic             regform,
   output logic [SEL_W-1:0] rsel,
   output logic [1:0]       len,
   output logic             legal
);

   localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NREGS - 1);

   logic code_ok;
   logic code_zero;

   assign opc       = opc_e'(hdr[7:4]);
   assign regform   = hdr[3];
   assign rsel      = hdr[SEL_W-1:0];
   assign code_ok   = (rsel <= LAST_CODE);
   assign code_zero = (rsel == '0);

   always_comb begin
      len   = 2'd2;
      legal = code_ok;
      unique case (opc)
         OP_LD, OP_ST: begin
            len = regform ? 2'd1 : 2'd3;
         end
         OP_PUSH, OP_JNZ: begin
            len   = regform ? 2'd1 : 2'd2;
            legal = regform ? code_ok : code_zero;
         end
         OP_POP: begin
            len   = 2'd1;
            legal = regform && code_ok;
         end
         OP_LDP: begin
            len   = 2'd3;
            legal = !regform && code_zero;
         end
         default: begin
            len = 2'd2;
         end
      endcase
   end

   always_comb begin
      if (legal) begin
         assert (len != 2'd0) else $error("p_len_nonzero_r2");
      end
   end

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
   import cpu8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  opc_e         opc,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] y,
   output flags_t       f
);

   logic [W:0] ext_a;
   logic [W:0] ext_b;
   logic [W:0] ext_c;
   logic [W:0] res;

   assign ext_a = {1'b0, a};
   assign ext_b = {1'b0, b};
   assign ext_c = (W+1)'(cin);

   always_comb begin
      unique case (opc)
         OP_ADD:  res = ext_a + ext_b;
         OP_ADC:  res = ext_a + ext_b + ext_c;
         OP_SBB:  res = ext_a - ext_b - ext_c;
         OP_CMP:  res = ext_a - ext_b;
         OP_AND:  res = {1'b0, a & b};
         OP_OR:   res = {1'b0, a | b};
         OP_NOR:  res = {1'b0, ~(a | b)};
         default: res = ext_b;
      endcase
   end

   assign y       = res[W-1:0];
   assign f.carry = res[W];
   assign f.zero  = (res[W-1:0] == '0);
   assign f.less  = (a < b);
   assign f.equal = (a == b);

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
   parameter int unsigned W     = 8,
   parameter int unsigned NREGS = 6,
   parameter int unsigned SEL_W = 3,
   parameter int unsigned HI_IX = 4,
   parameter int unsigned LO_IX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] wsel,
   input  logic [W-1:0]     wdata,
   input  logic [SEL_W-1:0] sel_a,
   input  logic [SEL_W-1:0] sel_b,
   output logic [W-1:0]     rd_a,
   output logic [W-1:0]     rd_b,
   output logic [2*W-1:0]   ptr
);

   logic [W-1:0] q [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q[g] <= '0;
         end else if (we && (wsel == SEL_W'(g))) begin
            q[g] <= wdata;
         end
      end
   end

   always_comb begin
      rd_a = '0;
      rd_b = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (sel_a == SEL_W'(i)) rd_a = q[i];
         if (sel_b == SEL_W'(i)) rd_b = q[i];
      end
   end

   assign ptr = {q[HI_IX], q[LO_IX]};

   p_wsel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (wsel < SEL_W'(NREGS)));

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
   import cpu8_pkg::*;
#(
   parameter int unsigned    DATA_W   = 8,
   parameter int unsigned    ADDR_W   = 16,
   parameter int unsigned    NREGS    = 6,
   parameter int unsigned    SEL_W    = 3,
   parameter logic [15:0]    PC_RESET = 16'h0000,
   parameter logic [15:0]    SP_RESET = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] io_port,
   output logic              io_rd,
   output logic              io_wr,
   output logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] io_rdata,
   output logic [3:0]        flags,
   output logic              halted,
   output logic              fault
);

   localparam logic [DATA_W-1:0] LAST_CODE = DATA_W'(NREGS - 1);
   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

   if (DATA_W != 8) begin : g_bad_width
      $error("cpu8_core: header layout needs DATA_W == 8");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
      $error("cpu8_core: pointer pair needs ADDR_W == 2*DATA_W");
   end
   if (NREGS < 6 || NREGS > (1 << SEL_W)) begin : g_bad_regs
      $error("cpu8_core: register count does not fit the code field");
   end

   state_e            state_q;
   logic [ADDR_W-1:0] pc_q, sp_q;
   logic [7:0]        ir_q;
   logic [DATA_W-1:0] op1_q, op2_q;
   flags_t            flags_q;
   logic              fault_q;

   // decoder on the raw fetch byte: steers the fetch cycle only
   opc_e             f_opc;
   logic             f_regform;
   logic [SEL_W-1:0] f_rsel;
   logic [1:0]       f_len;
   logic             f_legal;

   // decoder on the latched header: steers everything after fetch
   opc_e             d_opc;
   logic             d_regform;
   logic [SEL_W-1:0] d_rsel;
   logic [1:0]       d_len;
   logic             d_legal;

   cpu8_decode #(.SEL_W(SEL_W), .NREGS(NREGS)) i_dec_fetch (
      .hdr(mem_rdata), .opc(f_opc), .regform(f_regform),
      .rsel(f_rsel), .len(f_len), .legal(f_legal)
   );

   cpu8_decode #(.SEL_W(SEL_W), .NREGS(NREGS)) i_dec_hold (
      .hdr(ir_q), .opc(d_opc), .regform(d_regform),
      .rsel(d_rsel), .len(d_len), .legal(d_legal)
   );

   logic              rf_we;
   logic [SEL_W-1:0]  rf_wsel;
   logic [DATA_W-1:0] rf_wdata;
   logic [DATA_W-1:0] named_val, coded_val;
   logic [ADDR_W-1:0] ptr;

   cpu8_regfile #(
      .W(DATA_W), .NREGS(NREGS), .SEL_W(SEL_W),
      .HI_IX(IDX_H), .LO_IX(IDX_Z)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .we(rf_we), .wsel(rf_wsel), .wdata(rf_wdata),
      .sel_a(d_rsel), .sel_b(op1_q[SEL_W-1:0]),
      .rd_a(named_val), .rd_b(coded_val), .ptr(ptr)
   );

   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] alu_y;
   flags_t            alu_f;

   assign operand = d_regform ? coded_val : op1_q;

   cpu8_alu #(.W(DATA_W)) i_alu (
      .opc(d_opc), .a(named_val), .b(operand), .cin(flags_q.carry),
      .y(alu_y), .f(alu_f)
   );

   logic              two_byte;
   logic              bad_src;
   logic              is_alu;
   logic              alu_writes;
   logic              in_exec;
   logic [ADDR_W-1:0] abs_addr;
   logic [ADDR_W-1:0] data_addr;
   logic [DATA_W-1:0] single_val;

   assign two_byte   = (d_opc == OP_MOV) || (d_opc >= OP_IN);
   assign bad_src    = two_byte && d_regform && (op1_q > LAST_CODE);
   assign is_alu     = (d_opc >= OP_ADD);
   assign alu_writes = is_alu && (d_opc != OP_CMP);
   assign in_exec    = (state_q == S_EXEC) && !bad_src;
   assign abs_addr   = {op2_q, op1_q};
   assign data_addr  = d_regform ? ptr : abs_addr;
   assign single_val = d_regform ? named_val : op1_q;

   // bus strobes
   always_comb begin
      mem_addr  = pc_q;
      mem_rd    = 1'b0;
      mem_wr    = 1'b0;
      mem_wdata = named_val;
      io_port   = operand;
      io_rd     = 1'b0;
      io_wr     = 1'b0;
      io_wdata  = named_val;
      unique case (state_q)
         S_FETCH, S_OPND1, S_OPND2: mem_rd = 1'b1;
         S_EXEC: begin
            if (!bad_src) begin
               unique case (d_opc)
                  OP_LD:   begin mem_addr = data_addr; mem_rd = 1'b1; end
                  OP_ST:   begin mem_addr = data_addr; mem_wr = 1'b1; end
                  OP_PUSH: begin
                     mem_addr  = sp_q - ONE;
                     mem_wr    = 1'b1;
                     mem_wdata = single_val;
                  end
                  OP_POP:  begin mem_addr = sp_q;     mem_rd = 1'b1; end
                  OP_LDP:  begin mem_addr = abs_addr; mem_rd = 1'b1; end
                  OP_IN:   io_rd = 1'b1;
                  OP_OUT:  io_wr = 1'b1;
                  default: ;
               endcase
            end
         end
         S_PTRHI: begin mem_addr = abs_addr + ONE; mem_rd = 1'b1; end
         default: ;
      endcase
   end

   // register file write port
   always_comb begin
      rf_we    = 1'b0;
      rf_wsel  = d_rsel;
      rf_wdata = alu_y;
      if (in_exec) begin
         unique case (d_opc)
            OP_MOV:        begin rf_we = 1'b1; rf_wdata = operand;   end
            OP_LD, OP_POP: begin rf_we = 1'b1; rf_wdata = mem_rdata; end
            OP_IN:         begin rf_we = 1'b1; rf_wdata = io_rdata;  end
            OP_LDP: begin
               rf_we    = 1'b1;
               rf_wsel  = SEL_W'(IDX_Z);
               rf_wdata = mem_rdata;
            end
            default:       rf_we = alu_writes;
         endcase
      end else if (state_q == S_PTRHI) begin
         rf_we    = 1'b1;
         rf_wsel  = SEL_W'(IDX_H);
         rf_wdata = mem_rdata;
      end
   end

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_FETCH;
         pc_q    <= PC_RESET;
         sp_q    <= SP_RESET;
         ir_q    <= '0;
         op1_q   <= '0;
         op2_q   <= '0;
         flags_q <= '0;
         fault_q <= 1'b0;
      end else begin
         unique case (state_q)
            S_FETCH: begin
               ir_q <= mem_rdata;
               pc_q <= pc_q + ONE;
               if (!f_legal) begin
                  fault_q <= 1'b1;
                  state_q <= S_HALT;
               end else begin
                  state_q <= (f_len == 2'd1) ? S_EXEC : S_OPND1;
               end
            end
            S_OPND1: begin
               op1_q   <= mem_rdata;
               pc_q    <= pc_q + ONE;
               state_q <= (d_len == 2'd3) ? S_OPND2 : S_EXEC;
            end
            S_OPND2: begin
               op2_q   <= mem_rdata;
               pc_q    <= pc_q + ONE;
               state_q <= S_EXEC;
            end
            S_EXEC: begin
               if (bad_src) begin
                  fault_q <= 1'b1;
                  state_q <= S_HALT;
               end else begin
                  state_q <= (d_opc == OP_LDP) ? S_PTRHI : S_FETCH;
                  if (is_alu) flags_q <= alu_f;
                  if (d_opc == OP_PUSH) sp_q <= sp_q - ONE;
                  if (d_opc == OP_POP)  sp_q <= sp_q + ONE;
                  if ((d_opc == OP_JNZ) && (single_val != '0)) pc_q <= ptr;
               end
            end
            S_PTRHI: state_q <= S_FETCH;
            default: state_q <= S_HALT;
         endcase
      end
   end

   assign flags  = flags_q;
   assign halted = (state_q == S_HALT);
   assign fault  = fault_q;

   p_rdwr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_io_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_wr));

   p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !(mem_rd || mem_wr || io_rd || io_wr));

   p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(fault)));

   p_fault_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> halted);

   p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_OPND1 || state_q == S_OPND2) |=> (pc_q == $past(pc_q) + ONE));

   p_hdr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_FETCH && f_legal) |=>
         (d_opc == $past(f_opc) && d_rsel == $past(f_rsel)
          && d_regform == $past(f_regform)));

   p_push_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && d_opc == OP_PUSH) |=> (sp_q == $past(sp_q) - ONE));

   p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && d_opc == OP_CMP) |-> !rf_we);

endmodule

// File: tb/test_cpu8_core.sv
module test_cpu8_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [7:0]  io_port, io_wdata, io_rdata;
   logic        io_rd, io_wr;
   logic [3:0]  flags;
   logic        halted, fault;

   int total = 0;
   int bad   = 0;
   int wp    = 0;
   int cycles = 0;

   logic [7:0] mem [0:4095];

   bit          q_io   [$];
   logic [15:0] q_addr [$];
   logic [7:0]  q_data [$];
   bit          q_fchk [$];
   logic [3:0]  q_flg  [$];
   string       q_req  [$];

   always #5 clk = ~clk;

   cpu8_core i_cpu8_core (
      .clk(clk), .rst_n(rst_n),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .io_port(io_port), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .flags(flags), .halted(halted), .fault(fault)
   );

   assign mem_rdata = mem[mem_addr[11:0]];
   assign io_rdata  = io_port ^ 8'hA5;

   always @(posedge clk) begin
      if (rst_n && mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
   end

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic put(logic [7:0] b);
      mem[wp] = b;
      wp++;
   endtask

   task automatic exp_w(bit io, logic [15:0] a, logic [7:0] d, string r);
      q_io.push_back(io); q_addr.push_back(a); q_data.push_back(d);
      q_fchk.push_back(1'b0); q_flg.push_back(4'h0); q_req.push_back(r);
   endtask

   task automatic exp_wf(logic [7:0] port, logic [7:0] d, logic [3:0] f, string r);
      q_io.push_back(1'b1); q_addr.push_back({8'h00, port}); q_data.push_back(d);
      q_fchk.push_back(1'b1); q_flg.push_back(f); q_req.push_back(r);
   endtask

   // monitor: every strobe write is popped from the scoreboard
   always @(negedge clk) begin
      if (rst_n && (mem_wr || io_wr)) begin
         if (q_io.size() == 0) begin
            total++; bad++;
            $display("FAIL R12 unexpected write io=%0d addr=%0h data=%0h expected none",
                     io_wr, io_wr ? {8'h00, io_port} : mem_addr, io_wr ? io_wdata : mem_wdata);
         end else begin
            automatic bit          e_io = q_io.pop_front();
            automatic logic [15:0] e_a  = q_addr.pop_front();
            automatic logic [7:0]  e_d  = q_data.pop_front();
            automatic bit          e_fc = q_fchk.pop_front();
            automatic logic [3:0]  e_f  = q_flg.pop_front();
            automatic string       e_r  = q_req.pop_front();
            chk({e_r, " kind"}, {31'd0, io_wr}, {31'd0, e_io});
            chk({e_r, " addr"}, io_wr ? {24'd0, io_port} : {16'd0, mem_addr}, {16'd0, e_a});
            chk({e_r, " data"}, io_wr ? {24'd0, io_wdata} : {24'd0, mem_wdata}, {24'd0, e_d});
            if (e_fc) chk({e_r, " flags"}, {28'd0, flags}, {28'd0, e_f});
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      wp = 0;
   endtask

   task automatic run_prog(string r, bit exp_fault);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: first cycle after reset reads address 0, core idle of faults
      chk("R1 reset addr", {16'd0, mem_addr}, 32'h0);
      chk("R1 reset rd",   {31'd0, mem_rd},   32'h1);
      chk("R1 reset halted", {31'd0, halted}, 32'h0);
      chk("R1 reset fault",  {31'd0, fault},  32'h0);
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         if (halted) break;
      end
      chk({r, " halted"}, {31'd0, halted}, 32'h1);
      chk({r, " fault"},  {31'd0, fault}, {31'd0, exp_fault});
      chk({r, " quiet"},  {30'd0, mem_rd, io_wr}, 32'h0);
      chk("R2 all expected writes seen", q_io.size(), 0);
   endtask

   int zpos;

   initial begin
      clear_mem();
      // R3 move literal / register, port out literal
      put(8'h00); put(8'h3C); put(8'h80); put(8'h10); exp_w(1, 16'h10, 8'h3C, "R3");
      put(8'h09); put(8'h00); put(8'h81); put(8'h11); exp_w(1, 16'h11, 8'h3C, "R3");
      // R4 overflowing add then add-with-carry
      put(8'h90); put(8'hD0); put(8'hA1); put(8'h01);
      put(8'h81); put(8'h12); exp_w(1, 16'h12, 8'h3E, "R4");
      // R5 AND, OR, NOR
      put(8'h02); put(8'hF0); put(8'hB2); put(8'h3C); put(8'hC2); put(8'h05);
      put(8'hD2); put(8'h0F); put(8'h82); put(8'h13); exp_w(1, 16'h13, 8'hC0, "R5");
      // R6 borrow chain
      put(8'h03); put(8'h05); put(8'hF3); put(8'h07); put(8'hF3); put(8'h00);
      put(8'h83); put(8'h14); exp_w(1, 16'h14, 8'hFD, "R6");
      // R6 compare: equal case, then less-with-borrow case; no register written
      put(8'hE3); put(8'hFD); put(8'h83); put(8'h16); exp_wf(8'h16, 8'hFD, 4'b0101, "R6");
      put(8'hE0); put(8'h0D); put(8'h80); put(8'h22); exp_wf(8'h22, 8'h0C, 4'b1010, "R6");
      put(8'h01); put(8'h00); put(8'hA1); put(8'h00);
      put(8'h81); put(8'h15); exp_w(1, 16'h15, 8'h01, "R6");
      // R4 register-form add
      put(8'h98); put(8'h01); put(8'h80); put(8'h17); exp_w(1, 16'h17, 8'h0D, "R4");
      // R7 absolute store
      put(8'h20); put(8'h00); put(8'h08); exp_w(0, 16'h0800, 8'h0D, "R7");
      // R8 pointer load, R7 pointer store and load
      mem[12'h900] = 8'h34; mem[12'h901] = 8'h08;
      put(8'h50); put(8'h00); put(8'h09);
      put(8'h2A); exp_w(0, 16'h0834, 8'hC0, "R7");
      put(8'h1B); put(8'h83); put(8'h18); exp_w(1, 16'h18, 8'hC0, "R7");
      put(8'h11); put(8'h00); put(8'h09); put(8'h81); put(8'h19); exp_w(1, 16'h19, 8'h34, "R7");
      put(8'h84); put(8'h20); exp_w(1, 16'h20, 8'h08, "R8");
      put(8'h85); put(8'h21); exp_w(1, 16'h21, 8'h34, "R8");
      // R9 push register, push literal, pop twice
      put(8'h38); exp_w(0, 16'hFFFE, 8'h0D, "R9");
      put(8'h30); put(8'h77); exp_w(0, 16'hFFFD, 8'h77, "R9");
      put(8'h4A); put(8'h4B);
      put(8'h82); put(8'h1A); exp_w(1, 16'h1A, 8'h77, "R9");
      put(8'h83); put(8'h1B); exp_w(1, 16'h1B, 8'h0D, "R9");
      // R11 port in literal and register forms, port out register form
      put(8'h70); put(8'h40); put(8'h80); put(8'h1C); exp_w(1, 16'h1C, 8'hE5, "R11");
      put(8'h02); put(8'h41); put(8'h79); put(8'h02);
      put(8'h89); put(8'h02); exp_w(1, 16'h41, 8'hE4, "R11");
      // R10 jump not taken, then taken over a forbidden output
      put(8'h04); put(8'h00); put(8'h05); zpos = wp; put(8'h00);
      put(8'h60); put(8'h00); put(8'h80); put(8'h1E); exp_w(1, 16'h1E, 8'hE5, "R10");
      put(8'h68); put(8'h80); put(8'h1F);
      mem[zpos] = 8'(wp);
      put(8'h80); put(8'h1D); exp_w(1, 16'h1D, 8'hE5, "R10");
      put(8'hFF);
      run_prog("R12 end of main", 1'b1);

      // R12 out-of-range source code in second byte
      clear_mem();
      put(8'h08); put(8'h06);
      run_prog("R12 bad source", 1'b1);

      // R12 pop without register-form bit
      clear_mem();
      put(8'h40);
      run_prog("R12 bad pop", 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule